// File: doc/BRIEF.md
# Floppy Controller Soft-Switch Front End

This block is the register front end that a processor sees when it talks to a two-drive floppy disk controller. Eight one-bit switches live inside it. Every bus access, read or write, picks one switch from the address and sets or clears it. Three of the switches are head-phase lines and one is a strobe. One is the motor enable and one picks the active drive. The last two (called Q6 and Q7 here) choose which byte a read returns and what a write stores.

A write with both Q6 and Q7 set loads either the mode register (motor enable off) or the outgoing data buffer (motor enable on). Reads return the incoming data byte, a status byte or a write-handshake byte. The incoming data byte, the handshake flags and the sense line arrive as inputs from the shifters and the drive; those parts sit outside this block. The block drives one enable per drive and a bundle of control lines for the selected drive. When the motor enable is cleared, a hold-off counter can keep the drive spinning for `CLK_HZ` clock cycles (one second).

Top module: `fsw_front`

## Requirements
- R1: On each cycle with `bus_valid` high, switch number `bus_addr[3:1]` takes the value `bus_addr[0]`, for reads and writes alike. The switch numbers are: 0..2 phase lines, 3 strobe, 4 motor enable, 5 drive select, 6 Q6, 7 Q7.
- R2: A read at an odd address returns 0xFF.
- R3: A read at an even address returns `rx_byte` when, after the access, Q6=0 and Q7=0.
- R4: With Q6=1 and Q7=0 after the access, an even read returns a status byte. Bits 4:0 are mode bits 4:0, bit 5 is the motor enable switch, bit 6 is 0 and bit 7 is `drive_sense`.
- R5: With Q6=0 and Q7=1 after the access, an even read returns a handshake byte. Bits 5:0 are 1, bit 6 is `wr_no_underrun` and bit 7 is `wr_buf_ready`.
- R6: With Q6=1 and Q7=1 after the access, an even read returns 0xFF.
- R7: A write that leaves Q6=1, Q7=1 and motor enable 0 loads `bus_wdata` into `mode_q`. No other access changes `mode_q`.
- R8: A write that leaves Q6=1, Q7=1 and motor enable 1 loads `wbuf_data` and pulses `wbuf_load` for one cycle. `mode_q` is left unchanged.
- R9: Clearing the motor enable while `mode_q[2]`=0 keeps the selected drive enabled for exactly `CLK_HZ` cycles after the access edge, then turns it off.
- R10: Clearing the motor enable while `mode_q[2]`=1 turns the drive off at the access edge.
- R11: Setting the motor enable turns the selected drive on at the access edge and cancels any pending hold-off.
- R12: At most one drive enable is high. `drv_enable[i]` is high only when the drive select switch equals i, and the motor enable or a running hold-off is present. A drive-select change therefore moves the enable at once.
- R13: `drv_ctrl` bits 0..2 are the phase switches, bit 3 is the strobe and bit 4 is `ext_select`. `ext_select` passes through combinationally.
- R14: After reset, all switches are 0, `mode_q` is 0, both drive enables are 0 and `wbuf_load` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Switch index in bits 3:1, set/clear in bit 0 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; combinational, reflects the switch state after the access |
| ext_select | input | 1 | Extra select line forwarded to the drive |
| rx_byte | input | 8 | Assembled byte from the read shifter |
| wr_no_underrun | input | 1 | Write shifter: no underrun so far |
| wr_buf_ready | input | 1 | Write shifter: buffer ready for a byte |
| drive_sense | input | 1 | Sense line of the selected drive |
| mode_q | output | 8 | Mode register |
| wbuf_data | output | 8 | Byte for the write shifter |
| wbuf_load | output | 1 | One-cycle pulse: `wbuf_data` was reloaded |
| drv_enable | output | 2 | Per-drive enable |
| drv_ctrl | output | 5 | Control lines for the selected drive |

## Verification
The bench checks the read decode against the switch state after the access, not before it. A design that decoded the old Q6/Q7 would return the wrong register on the very read that switches them, for example the status read at the address that clears Q7. The hold-off window is counted to the exact cycle on both sides, so a counter that is one cycle short or one cycle long is reported. The bench also re-enables the motor in the middle of a hold-off and then waits past the old expiry; a design that does not cancel the pending disable drops the drive there. It switches drives while a hold-off runs, and a design that ties the enable to the old drive or ignores the running counter leaves the wrong drive spinning. Finally it loads the mode register and the data buffer back to back, which catches a design that mixes up which one the motor enable selects.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
   localparam int SW_COUNT = 8;
   localparam int SW_IDX_W = $clog2(SW_COUNT);

   // Switch numbering is decoded from address bits 3:1 and is behavioural.
   localparam int SW_PH0   = 0;
   localparam int SW_PH1   = 1;
   localparam int SW_PH2   = 2;
   localparam int SW_STRB  = 3;
   localparam int SW_MOTOR = 4;
   localparam int SW_DSEL  = 5;
   localparam int SW_Q6    = 6;
   localparam int SW_Q7    = 7;

   localparam int MODE_HOLD_OFF_BIT = 2;
   localparam int MODE_STATUS_BITS  = 5;
   localparam int CTRL_W            = 5;
   localparam int DRIVE_COUNT       = 2;

   typedef logic [SW_COUNT-1:0] sw_vec_t;

   typedef enum logic [1:0] {
      RSEL_DATA   = 2'b00,
      RSEL_STATUS = 2'b01,
      RSEL_HSHAKE = 2'b10,
      RSEL_NONE   = 2'b11
   } rsel_e;
endpackage

// File: rtl/fsw_switch_bank.sv
module fsw_switch_bank
   import fsw_pkg::*;
#(
   parameter int SW_N  = SW_COUNT,
   parameter int IDX_W = SW_IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_valid,
   input  logic [IDX_W:0]   acc_addr,
   output logic [SW_N-1:0]  sw_q,
   output logic [SW_N-1:0]  sw_nx
);
   if (SW_N != (1 << IDX_W)) begin : g_bad_size
      $error("fsw_switch_bank: SW_N must equal 2**IDX_W");
   end

   for (genvar g = 0; g < SW_N; g++) begin : g_sw
      logic hit;
      assign hit      = acc_valid && (acc_addr[IDX_W:1] == IDX_W'(g));
      assign sw_nx[g] = hit ? acc_addr[0] : sw_q[g];

      always_ff @(posedge clk) begin
         if (!rst_n) sw_q[g] <= 1'b0;
         else        sw_q[g] <= sw_nx[g];
      end
   end
endmodule

// File: rtl/fsw_motor_timer.sv
module fsw_motor_timer #(
   parameter int CLK_HZ      = 8_000_000,
   parameter bit HOLD_ENABLE = 1'b1,
   localparam int CNT_W      = $clog2(CLK_HZ + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_set,
   input  logic en_clr,
   input  logic delay_ok,
   output logic running
);
   if (CLK_HZ < 1) begin : g_bad_rate
      $error("fsw_motor_timer: CLK_HZ must be at least 1");
   end

   if (HOLD_ENABLE) begin : g_hold
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (en_set) begin
            cnt_q <= '0;
         end else if (en_clr) begin
            cnt_q <= delay_ok ? CNT_W'(CLK_HZ) : '0;
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end

      assign running = (cnt_q != '0);
   end else begin : g_no_hold
      logic unused_tie;
      assign unused_tie = ^{clk, rst_n, en_set, en_clr, delay_ok};
      assign running    = 1'b0;
   end
endmodule

// File: rtl/fsw_read_mux.sv
module fsw_read_mux
   import fsw_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                        odd_addr,
   input  logic                        q6,
   input  logic                        q7,
   input  logic                        motor_sw,
   input  logic [MODE_STATUS_BITS-1:0] mode_lo,
   input  logic [DATA_W-1:0]           rx_byte,
   input  logic                        no_underrun,
   input  logic                        buf_ready,
   input  logic                        sense,
   output logic [DATA_W-1:0]           rdata
);
   localparam int FILL_W = DATA_W - 2;

   if (DATA_W != 8) begin : g_bad_width
      $error("fsw_read_mux: byte layout needs DATA_W of 8");
   end

   rsel_e rsel;
   assign rsel = rsel_e'({q7, q6});

   always_comb begin
      rdata = '1;
      if (!odd_addr) begin
         unique case (rsel)
            RSEL_DATA:   rdata = rx_byte;
            RSEL_STATUS: rdata = {sense, 1'b0, motor_sw, mode_lo};
            RSEL_HSHAKE: rdata = {buf_ready, no_underrun, {FILL_W{1'b1}}};
            RSEL_NONE:   rdata = '1;
         endcase
      end
   end
endmodule

// File: rtl/fsw_front.sv
module fsw_front
   import fsw_pkg::*;
#(
   parameter int CLK_HZ      = 8_000_000,
   parameter bit HOLD_ENABLE = 1'b1,
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_valid,
   input  logic                   bus_write,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [DATA_W-1:0]      bus_wdata,
   output logic [DATA_W-1:0]      bus_rdata,
   input  logic                   ext_select,
   input  logic [DATA_W-1:0]      rx_byte,
   input  logic                   wr_no_underrun,
   input  logic                   wr_buf_ready,
   input  logic                   drive_sense,
   output logic [DATA_W-1:0]      mode_q,
   output logic [DATA_W-1:0]      wbuf_data,
   output logic                   wbuf_load,
   output logic [DRIVE_COUNT-1:0] drv_enable,
   output logic [CTRL_W-1:0]      drv_ctrl
);
   if (ADDR_W != SW_IDX_W + 1) begin : g_bad_addr
      $error("fsw_front: ADDR_W must be SW_IDX_W+1");
   end

   sw_vec_t sw_q;
   sw_vec_t sw_nx;

   fsw_switch_bank #(.SW_N(SW_COUNT), .IDX_W(SW_IDX_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_valid (bus_valid),
      .acc_addr  (bus_addr),
      .sw_q      (sw_q),
      .sw_nx     (sw_nx)
   );

   // Motor enable edges caused by this access.
   logic motor_up, motor_down, hold_run;
   assign motor_up   = bus_valid && !sw_q[SW_MOTOR] &&  sw_nx[SW_MOTOR];
   assign motor_down = bus_valid &&  sw_q[SW_MOTOR] && !sw_nx[SW_MOTOR];

   fsw_motor_timer #(.CLK_HZ(CLK_HZ), .HOLD_ENABLE(HOLD_ENABLE)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_set   (motor_up),
      .en_clr   (motor_down),
      .delay_ok (!mode_q[MODE_HOLD_OFF_BIT]),
      .running  (hold_run)
   );

   fsw_read_mux #(.DATA_W(DATA_W)) u_rmux (
      .odd_addr    (bus_addr[0]),
      .q6          (sw_nx[SW_Q6]),
      .q7          (sw_nx[SW_Q7]),
      .motor_sw    (sw_nx[SW_MOTOR]),
      .mode_lo     (mode_q[MODE_STATUS_BITS-1:0]),
      .rx_byte     (rx_byte),
      .no_underrun (wr_no_underrun),
      .buf_ready   (wr_buf_ready),
      .sense       (drive_sense),
      .rdata       (bus_rdata)
   );

   // Writes decode on the switch state after this access.
   logic store_sel, mode_we, wbuf_we;
   assign store_sel = bus_valid && bus_write && sw_nx[SW_Q6] && sw_nx[SW_Q7];
   assign mode_we   = store_sel && !sw_nx[SW_MOTOR];
   assign wbuf_we   = store_sel &&  sw_nx[SW_MOTOR];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q    <= '0;
         wbuf_data <= '0;
         wbuf_load <= 1'b0;
      end else begin
         if (mode_we) mode_q <= bus_wdata;
         if (wbuf_we) wbuf_data <= bus_wdata;
         wbuf_load <= wbuf_we;
      end
   end

   logic spin;
   assign spin = sw_q[SW_MOTOR] || hold_run;

   for (genvar d = 0; d < DRIVE_COUNT; d++) begin : g_drv
      assign drv_enable[d] = spin && (sw_q[SW_DSEL] == d[0]);
   end

   assign drv_ctrl = {ext_select, sw_q[SW_STRB], sw_q[SW_PH2], sw_q[SW_PH1], sw_q[SW_PH0]};
endmodule

// File: rtl/fsw_front_chk.sv
module fsw_front_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_valid,
   input logic       bus_write,
   input logic [3:0] bus_addr,
   input logic [7:0] bus_rdata,
   input logic [7:0] mode_q,
   input logic [1:0] drv_enable,
   input logic [7:0] sw_q
);
   AST_ODD_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && bus_addr[0]) |-> (bus_rdata == 8'hFF)); // R2

   AST_STATUS_BIT6_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && bus_addr == 4'hE && sw_q[6]) |-> !bus_rdata[6]); // R4

   AST_HSHAKE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && bus_addr == 4'hC && sw_q[7]) |-> (bus_rdata[5:0] == 6'h3F)); // R5

   AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && bus_write) |=> $stable(mode_q)); // R7

   AST_FAST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_addr == 4'h8 && mode_q[2]) |=> (drv_enable == 2'b00)); // R10

   AST_ON_AT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_addr == 4'h9) |=> (drv_enable != 2'b00)); // R11

   AST_ONE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(drv_enable)); // R12
endmodule

bind fsw_front fsw_front_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_valid  (bus_valid),
   .bus_write  (bus_write),
   .bus_addr   (bus_addr),
   .bus_rdata  (bus_rdata),
   .mode_q     (mode_q),
   .drv_enable (drv_enable),
   .sw_q       (sw_q)
);

// File: tb/sim_fsw_front.sv
module sim_fsw_front;
   localparam int N = 20;
   localparam int NV = 15;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_valid = 1'b0;
   logic       bus_write = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       ext_select = 1'b0;
   logic [7:0] rx_byte = 8'h5A;
   logic       wr_no_underrun = 1'b1;
   logic       wr_buf_ready = 1'b0;
   logic       drive_sense = 1'b1;
   logic [7:0] mode_q, wbuf_data;
   logic       wbuf_load;
   logic [1:0] drv_enable;
   logic [4:0] drv_ctrl;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   fsw_front #(.CLK_HZ(N)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ext_select(ext_select), .rx_byte(rx_byte), .wr_no_underrun(wr_no_underrun),
      .wr_buf_ready(wr_buf_ready), .drive_sense(drive_sense), .mode_q(mode_q),
      .wbuf_data(wbuf_data), .wbuf_load(wbuf_load), .drv_enable(drv_enable),
      .drv_ctrl(drv_ctrl)
   );

   // {write, addr, wdata, expected read, check}
   localparam logic [21:0] VEC [NV] = '{
      {1'b0, 4'h1, 8'h00, 8'hFF, 1'b1},
      {1'b0, 4'hC, 8'h00, 8'h5A, 1'b1},
      {1'b0, 4'hD, 8'h00, 8'hFF, 1'b1},
      {1'b0, 4'hE, 8'h00, 8'h80, 1'b1},
      {1'b1, 4'hF, 8'h1F, 8'h00, 1'b0},
      {1'b0, 4'hE, 8'h00, 8'h9F, 1'b1},
      {1'b0, 4'h9, 8'h00, 8'hFF, 1'b1},
      {1'b0, 4'h6, 8'h00, 8'hBF, 1'b1},
      {1'b0, 4'hC, 8'h00, 8'h5A, 1'b1},
      {1'b0, 4'hF, 8'h00, 8'hFF, 1'b1},
      {1'b0, 4'hC, 8'h00, 8'h7F, 1'b1},
      {1'b0, 4'hD, 8'h00, 8'hFF, 1'b1},
      {1'b0, 4'h0, 8'h00, 8'hFF, 1'b1},
      {1'b1, 4'hF, 8'hA5, 8'h00, 1'b0},
      {1'b0, 4'hE, 8'h00, 8'hBF, 1'b1}
   };

   function automatic string row_req(int i);
      case (i)
         0, 2, 6, 9, 11: return "R2";
         1, 8:           return "R3";
         3, 7:           return "R4";
         5:              return "R7";
         10:             return "R5";
         12:             return "R6";
         14:             return "R8";
         default:        return "R1";
      endcase
   endfunction

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic acc(logic wr, logic [3:0] a, logic [7:0] wd, output logic [7:0] rd);
      @(negedge clk);
      bus_valid = 1'b1;
      bus_write = wr;
      bus_addr  = a;
      bus_wdata = wd;
      #2 rd = bus_rdata;
      @(negedge clk);
      bus_valid = 1'b0;
      bus_write = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      repeat (3) @(negedge clk);
      // R14 reset state
      check("R14", {6'd0, drv_enable}, 8'h00);
      check("R14", mode_q, 8'h00);
      check("R14", {3'd0, drv_ctrl}, 8'h00);
      check("R14", {7'd0, wbuf_load}, 8'h00);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         acc(VEC[i][21], VEC[i][20:17], VEC[i][16:9], rd);
         if (VEC[i][0]) check(row_req(i), rd, VEC[i][8:1]);
      end
      check("R8", wbuf_data, 8'hA5);
      check("R7", mode_q, 8'h1F);

      // R1 / R13 control lines: phase0 cleared by row 12, strobe cleared
      acc(1'b0, 4'h7, 8'h00, rd);
      ext_select = 1'b1;
      #1 check("R13", {3'd0, drv_ctrl}, 8'b0001_1000);
      check("R11", {6'd0, drv_enable}, 8'h01);
      acc(1'b0, 4'h3, 8'h00, rd);
      check("R1", {3'd0, drv_ctrl}, 8'b0001_1010);
      ext_select = 1'b0;
      #1 check("R13", {3'd0, drv_ctrl}, 8'b0000_1010);

      // R8 buffer load with motor on; Q6=1 already
      acc(1'b1, 4'hF, 8'h3C, rd);
      check("R8", {7'd0, wbuf_load}, 8'h01);
      check("R8", wbuf_data, 8'h3C);
      check("R8", mode_q, 8'h1F);
      @(negedge clk);
      check("R8", {7'd0, wbuf_load}, 8'h00);

      // R5 handshake with other flag values
      wr_buf_ready = 1'b1;
      wr_no_underrun = 1'b0;
      acc(1'b0, 4'hC, 8'h00, rd);
      check("R5", rd, 8'hBF);

      // R12 drive select moves enable
      acc(1'b0, 4'hB, 8'h00, rd);
      check("R12", {6'd0, drv_enable}, 8'h02);

      // R10 immediate off with mode bit 2 set
      acc(1'b0, 4'h8, 8'h00, rd);
      check("R10", {6'd0, drv_enable}, 8'h00);

      // R7 mode load with motor off
      acc(1'b0, 4'hD, 8'h00, rd);
      acc(1'b1, 4'hF, 8'h0B, rd);
      check("R7", mode_q, 8'h0B);
      check("R7", wbuf_data, 8'h3C);

      // R9 hold-off length
      acc(1'b0, 4'h9, 8'h00, rd);
      acc(1'b0, 4'h8, 8'h00, rd);
      repeat (N - 1) @(negedge clk);
      check("R9", {6'd0, drv_enable}, 8'h02);
      @(negedge clk);
      check("R9", {6'd0, drv_enable}, 8'h00);

      // R11 set during hold-off cancels it
      acc(1'b0, 4'h9, 8'h00, rd);
      acc(1'b0, 4'h8, 8'h00, rd);
      repeat (3) @(negedge clk);
      acc(1'b0, 4'h9, 8'h00, rd);
      repeat (N + 3) @(negedge clk);
      check("R11", {6'd0, drv_enable}, 8'h02);

      // R12 select change during hold-off
      acc(1'b0, 4'h8, 8'h00, rd);
      acc(1'b0, 4'hA, 8'h00, rd);
      check("R12", {6'd0, drv_enable}, 8'h01);
      repeat (N) @(negedge clk);
      check("R12", {6'd0, drv_enable}, 8'h00);

      // R14 reset in mid-run
      acc(1'b0, 4'h9, 8'h00, rd);
      rst_n = 1'b0;
      @(negedge clk);
      check("R14", {6'd0, drv_enable}, 8'h00);
      check("R14", mode_q, 8'h00);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule